// File: doc/BRIEF.md
# Instruction Address Breakpoint Comparator

This block watches the stream of retiring instructions and compares each one against a parameterised bank of breakpoint channels. A channel holds a target virtual address, a per-bit don't-care mask, an address-space identifier (ASID) with its own use enable, and two action enables. The action enables choose whether a hit requests a debug exception, raises a trigger pulse, or does both. A hit also sets a sticky status bit in that channel, which stays set until the debugger clears it.

Configuration goes through a small word-wide register port. The port only works while the core is in debug mode. At other times writes are dropped and reads return zero. Bits 5:2 of the register address select the channel and bits 1:0 select the word within it. A synchronous soft reset clears the same state as the asynchronous hard reset.

Top module: `insn_brk_cmp`

## Requirements
- R1: After hard reset every channel register (address, mask, ASID, control including status) reads as zero, and `dbg_req` and `trig_out` are low.
- R2: An address bit whose mask bit is 1 is left out of the compare. An address bit whose mask bit is 0 must equal the PC bit for a hit.
- R3: With control bit 2 (ASID use) set, a hit also needs `asid` to equal the channel's ASID word. With control bit 2 clear, the ASID is not compared.
- R4: A hit on a channel with control bit 0 (break enable) set, on a cycle with `pc_valid` high, drives `dbg_req` high in the next cycle. There is no request when `pc_valid` is low or when no such channel hits.
- R5: A hit on a channel with control bit 1 (trigger enable) set drives `trig_out` high for the next cycle only.
- R6: A hit on a channel with bit 0 or bit 1 set sets control bit 3 (status). The bit stays set until a debug-mode write to the control word with bit 3 = 1 clears it. If a clear and a new hit fall in the same cycle, the bit stays set.
- R7: When several channels hit in one cycle, one `dbg_req` is raised, and all of their status bits become set on the same edge.
- R8: Register writes made while `dbg_mode` is low leave all state unchanged, and `reg_rdata` is zero while `dbg_mode` is low.
- R9: A channel index of `NCH` or above reads as zero, and writes to it have no effect.
- R10: Word select 0 holds the address, 1 holds the mask, 2 holds the ASID (zero-extended), and 3 holds the control word (bit0 break, bit1 trigger, bit2 ASID use, bit3 status, upper bits zero). Bits 2:0 of the control word are written directly.
- R11: `soft_rst` high at a clock edge clears all channel state and both outputs, the same as hard reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| dbg_mode | input | 1 | Core is in debug mode; enables the register port |
| pc_valid | input | 1 | An instruction retires this cycle |
| pc | input | AW | Virtual address of the retiring instruction |
| asid | input | ASW | Current address-space identifier |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Bits 5:2 select the channel, bits 1:0 select the word |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data (combinational) |
| dbg_req | output | 1 | Debug exception request, one cycle after the hit |
| trig_out | output | 1 | Trigger pulse, one cycle after the hit |

## Verification
The bench targets PCs that differ from a programmed address only in masked bits, or only in a single unmasked bit. A design that inverts the mask sense, or that ignores the mask, raises requests on the wrong PCs. The bench also checks ASID matches with the ASID use bit set and cleared, since a design that always compares, or never compares, misses or invents hits. A clear-while-hit cycle and a multi-channel hit catch status bits that are lost or set one at a time. Writes outside debug mode, and accesses to channel indices beyond the populated count, expose a design that leaks configuration through the port or aliases a missing channel onto a real one.

// File: rtl/ibrk_pkg.sv
package ibrk_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_MASK = 2'd1,
    SEL_ASID = 2'd2,
    SEL_CTRL = 2'd3
  } ibrk_sel_e;

  localparam int CTL_BRK = 0;
  localparam int CTL_TRG = 1;
  localparam int CTL_ASE = 2;
  localparam int CTL_HIT = 3;
  localparam int CTL_W   = 4;
endpackage

// File: rtl/ibrk_chan.sv
module ibrk_chan
  import ibrk_pkg::*;
#(
  parameter int AW  = 32,
  parameter int ASW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [AW-1:0]       wr_data,
  input  logic                pc_valid,
  input  logic [AW-1:0]       pc,
  input  logic [ASW-1:0]      asid,
  output logic [AW-1:0]       addr_q,
  output logic [AW-1:0]       mask_q,
  output logic [ASW-1:0]      asid_q,
  output logic [CTL_W-1:0]    ctrl_q,
  output logic                brk_hit,
  output logic                trg_hit
);
  logic [AW-1:0]    addr_d, mask_d;
  logic [ASW-1:0]   asid_d;
  logic [CTL_W-1:0] ctrl_d;
  logic             addr_ok, asid_ok, hit_any;

  always_comb begin
    addr_ok = ((pc ^ addr_q) & ~mask_q) == '0;
    asid_ok = !ctrl_q[CTL_ASE] || (asid == asid_q);
    hit_any = pc_valid && addr_ok && asid_ok &&
              (ctrl_q[CTL_BRK] || ctrl_q[CTL_TRG]);
    brk_hit = hit_any && ctrl_q[CTL_BRK];
    trg_hit = hit_any && ctrl_q[CTL_TRG];
  end

  always_comb begin
    addr_d = addr_q;
    mask_d = mask_q;
    asid_d = asid_q;
    ctrl_d = ctrl_q;
    if (wr_en) begin
      unique case (ibrk_sel_e'(wr_sel))
        SEL_ADDR: addr_d = wr_data;
        SEL_MASK: mask_d = wr_data;
        SEL_ASID: asid_d = wr_data[ASW-1:0];
        SEL_CTRL: begin
          ctrl_d[CTL_ASE:CTL_BRK] = wr_data[CTL_ASE:CTL_BRK];
          if (wr_data[CTL_HIT]) ctrl_d[CTL_HIT] = 1'b0;
        end
        default: ;
      endcase
    end
    if (hit_any) ctrl_d[CTL_HIT] = 1'b1;
    if (soft_rst) begin
      addr_d = '0;
      mask_d = '0;
      asid_d = '0;
      ctrl_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mask_q <= '0;
      asid_q <= '0;
      ctrl_q <= '0;
    end else begin
      addr_q <= addr_d;
      mask_q <= mask_d;
      asid_q <= asid_d;
      ctrl_q <= ctrl_d;
    end
  end

  // R6
  hit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CTL_HIT] && !soft_rst && !(wr_en && wr_sel == 2'd3 && wr_data[CTL_HIT]))
      |=> ctrl_q[CTL_HIT]);

  // R6
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[CTL_HIT]) |-> $past(pc_valid));

  // R11
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ctrl_q == '0 && addr_q == '0 && mask_q == '0));
endmodule

// File: rtl/ibrk_merge.sv
module ibrk_merge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic [N-1:0] brk_vec,
  input  logic [N-1:0] trg_vec,
  output logic         dbg_req,
  output logic         trig_out
);
  logic req_d, trg_d;

  always_comb begin
    req_d = !soft_rst && (|brk_vec);
    trg_d = !soft_rst && (|trg_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_req  <= 1'b0;
      trig_out <= 1'b0;
    end else begin
      dbg_req  <= req_d;
      trig_out <= trg_d;
    end
  end
endmodule

// File: rtl/insn_brk_cmp.sv
module insn_brk_cmp
  import ibrk_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int ASW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_rst,
  input  logic           dbg_mode,
  input  logic           pc_valid,
  input  logic [AW-1:0]  pc,
  input  logic [ASW-1:0] asid,
  input  logic           reg_wr,
  input  logic [5:0]     reg_addr,
  input  logic [AW-1:0]  reg_wdata,
  output logic [AW-1:0]  reg_rdata,
  output logic           dbg_req,
  output logic           trig_out
);
  localparam int NV = (NCH > 0) ? NCH : 1;

  logic [3:0]       ch_idx;
  logic [1:0]       ch_sel;
  logic [NV-1:0]    wr_en, brk_vec, trg_vec, hit_vec;
  logic [AW-1:0]    addr_a [NV];
  logic [AW-1:0]    mask_a [NV];
  logic [ASW-1:0]   asid_a [NV];
  logic [CTL_W-1:0] ctrl_a [NV];
  logic [NV*AW-1:0] addr_flat;

  assign ch_idx = reg_addr[5:2];
  assign ch_sel = reg_addr[1:0];

  for (genvar i = 0; i < NV; i++) begin : g_ch
    if (i < NCH) begin : g_live
      assign wr_en[i] = reg_wr && dbg_mode && (ch_idx == 4'(i));
      ibrk_chan #(.AW(AW), .ASW(ASW)) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_rst(soft_rst),
        .wr_en   (wr_en[i]),
        .wr_sel  (ch_sel),
        .wr_data (reg_wdata),
        .pc_valid(pc_valid),
        .pc      (pc),
        .asid    (asid),
        .addr_q  (addr_a[i]),
        .mask_q  (mask_a[i]),
        .asid_q  (asid_a[i]),
        .ctrl_q  (ctrl_a[i]),
        .brk_hit (brk_vec[i]),
        .trg_hit (trg_vec[i])
      );
    end else begin : g_none
      assign wr_en[i]   = 1'b0;
      assign addr_a[i]  = '0;
      assign mask_a[i]  = '0;
      assign asid_a[i]  = '0;
      assign ctrl_a[i]  = '0;
      assign brk_vec[i] = 1'b0;
      assign trg_vec[i] = 1'b0;
    end
    assign hit_vec[i] = ctrl_a[i][CTL_HIT];
    assign addr_flat[i*AW +: AW] = addr_a[i];
  end

  always_comb begin
    reg_rdata = '0;
    if (dbg_mode && (int'(ch_idx) < NCH)) begin
      for (int i = 0; i < NV; i++) begin
        if (ch_idx == 4'(i)) begin
          unique case (ibrk_sel_e'(ch_sel))
            SEL_ADDR: reg_rdata = addr_a[i];
            SEL_MASK: reg_rdata = mask_a[i];
            SEL_ASID: reg_rdata = {{(AW-ASW){1'b0}}, asid_a[i]};
            SEL_CTRL: reg_rdata = {{(AW-CTL_W){1'b0}}, ctrl_a[i]};
            default:  reg_rdata = '0;
          endcase
        end
      end
    end
  end

  ibrk_merge #(.N(NV)) u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_rst(soft_rst),
    .brk_vec (brk_vec),
    .trg_vec (trg_vec),
    .dbg_req (dbg_req),
    .trig_out(trig_out)
  );

  // R7
  req_has_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req |-> (|hit_vec));

  // R5
  trig_has_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> (|hit_vec));

  // R8
  locked_outside_dbg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_mode && !soft_rst) |=> $stable(addr_flat));
endmodule

// File: tb/insn_brk_cmp_tb.sv
module insn_brk_cmp_tb;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n, soft_rst, dbg_mode, pc_valid, reg_wr;
  logic [31:0] pc, reg_wdata;
  logic [7:0]  asid;
  logic [5:0]  reg_addr;
  logic [31:0] reg_rdata;
  logic        dbg_req, trig_out;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_addr [NCH];
  logic [31:0] m_mask [NCH];
  logic [7:0]  m_asid [NCH];
  logic [3:0]  m_ctl  [NCH];
  logic        e_req, e_trg;

  always #2 clk = ~clk;

  insn_brk_cmp #(.NCH(NCH), .AW(32), .ASW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .dbg_mode(dbg_mode),
    .pc_valid(pc_valid), .pc(pc), .asid(asid), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dbg_req(dbg_req), .trig_out(trig_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic m_hit(int i);
    return pc_valid && (((pc ^ m_addr[i]) & ~m_mask[i]) == 32'h0) &&
           (!m_ctl[i][2] || asid == m_asid[i]) && (m_ctl[i][1:0] != 2'b00);
  endfunction

  function automatic logic [31:0] m_read(logic [5:0] ad);
    int i = int'(ad[5:2]);
    if (!dbg_mode || i >= NCH) return 32'h0;
    case (ad[1:0])
      2'd0: return m_addr[i];
      2'd1: return m_mask[i];
      2'd2: return {24'h0, m_asid[i]};
      default: return {28'h0, m_ctl[i]};
    endcase
  endfunction

  task automatic m_clear();
    for (int i = 0; i < NCH; i++) begin
      m_addr[i] = '0; m_mask[i] = '0; m_asid[i] = '0; m_ctl[i] = '0;
    end
  endtask

  task automatic tick(input string tag);
    logic [NCH-1:0] nh;
    int wi;
    nh = '0; e_req = 1'b0; e_trg = 1'b0;
    for (int i = 0; i < NCH; i++)
      if (m_hit(i)) begin
        nh[i] = 1'b1; e_req |= m_ctl[i][0]; e_trg |= m_ctl[i][1];
      end
    wi = int'(reg_addr[5:2]);
    if (reg_wr && dbg_mode && wi < NCH) begin
      case (reg_addr[1:0])
        2'd0: m_addr[wi] = reg_wdata;
        2'd1: m_mask[wi] = reg_wdata;
        2'd2: m_asid[wi] = reg_wdata[7:0];
        default: begin
          m_ctl[wi][2:0] = reg_wdata[2:0];
          if (reg_wdata[3]) m_ctl[wi][3] = 1'b0;
        end
      endcase
    end
    for (int i = 0; i < NCH; i++) if (nh[i]) m_ctl[i][3] = 1'b1;
    if (soft_rst) begin
      m_clear(); e_req = 1'b0; e_trg = 1'b0;
    end
    @(posedge clk); @(negedge clk);
    chk({tag, " dbg_req"}, {31'h0, dbg_req}, {31'h0, e_req});
    chk({tag, " trig_out"}, {31'h0, trig_out}, {31'h0, e_trg});
  endtask

  task automatic idle_in();
    reg_wr = 1'b0; pc_valid = 1'b0; soft_rst = 1'b0;
  endtask

  task automatic wr(input int ch, input int sel, input logic [31:0] d);
    idle_in();
    reg_wr = 1'b1; reg_addr = {4'(ch), 2'(sel)}; reg_wdata = d;
    tick("R10 write");
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input int ch, input int sel);
    reg_addr = {4'(ch), 2'(sel)};
    #1;
    chk(tag, reg_rdata, m_read(reg_addr));
  endtask

  task automatic fetch(input string tag, input logic [31:0] a, input logic [7:0] s);
    idle_in();
    pc_valid = 1'b1; pc = a; asid = s;
    tick(tag);
    pc_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    m_clear();
    rst_n = 1'b0; soft_rst = 1'b0; dbg_mode = 1'b1; pc_valid = 1'b0;
    reg_wr = 1'b0; pc = '0; asid = '0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 dbg_req", {31'h0, dbg_req}, 32'h0);
    chk("R1 trig_out", {31'h0, trig_out}, 32'h0);
    for (int c = 0; c < NCH; c++)
      for (int s = 0; s < 4; s++) rd("R1 reset read", c, s);

    // R2 R4: masked address compare, break request
    wr(0, 0, 32'h1000_0040);
    wr(0, 1, 32'h0000_000F);
    wr(0, 3, 32'h1);
    rd("R10 addr word", 0, 0);
    rd("R10 mask word", 0, 1);
    rd("R10 ctrl word", 0, 3);
    fetch("R2 masked bits differ", 32'h1000_004C, 8'h0);
    chk("R4 request raised", {31'h0, dbg_req}, 32'h1);
    fetch("R2 unmasked bit differs", 32'h1000_0050, 8'h0);
    chk("R2 no request", {31'h0, dbg_req}, 32'h0);
    idle_in(); pc = 32'h1000_0040; tick("R4 no valid no request");

    // R3 R5: ASID-qualified trigger-only channel
    wr(1, 0, 32'h2000_0000);
    wr(1, 2, 32'h05);
    wr(1, 3, 32'h6);
    rd("R10 asid word", 1, 2);
    fetch("R3 wrong asid", 32'h2000_0000, 8'h06);
    chk("R3 no trigger", {31'h0, trig_out}, 32'h0);
    fetch("R5 right asid", 32'h2000_0000, 8'h05);
    chk("R5 trigger pulse", {31'h0, trig_out}, 32'h1);
    idle_in(); tick("R5 pulse ends");
    wr(1, 3, 32'h2);
    fetch("R3 asid ignored", 32'h2000_0000, 8'h77);
    chk("R3 trigger without asid", {31'h0, trig_out}, 32'h1);

    // R6: sticky status and write-1-clear
    rd("R6 status set", 1, 3);
    idle_in(); tick("R6 idle");
    rd("R6 status held", 1, 3);
    wr(1, 3, 32'hA);
    rd("R6 status cleared", 1, 3);
    idle_in(); reg_wr = 1'b1; reg_addr = {4'd1, 2'd3}; reg_wdata = 32'hA;
    pc_valid = 1'b1; pc = 32'h2000_0000;
    tick("R6 set beats clear");
    idle_in();
    rd("R6 set beats clear read", 1, 3);

    // R7: two channels at once
    wr(2, 0, 32'h3000_0100); wr(2, 1, 32'h0); wr(2, 3, 32'h1);
    wr(3, 0, 32'h3000_0000); wr(3, 1, 32'h0000_0FFF); wr(3, 3, 32'h1);
    fetch("R7 dual hit", 32'h3000_0100, 8'h0);
    rd("R7 ch2 status", 2, 3);
    rd("R7 ch3 status", 3, 3);

    // R8: port locked outside debug mode
    dbg_mode = 1'b0;
    wr(0, 0, 32'hDEAD_BEEF);
    wr(0, 3, 32'h8);
    rd("R8 read zero", 0, 0);
    dbg_mode = 1'b1;
    rd("R8 addr unchanged", 0, 0);
    rd("R8 status unchanged", 0, 3);

    // R9: unpopulated channel
    wr(6, 0, 32'h1234_5678);
    rd("R9 missing reads zero", 6, 0);
    for (int c = 0; c < NCH; c++) rd("R9 no alias", c, 0);

    // R11: soft reset
    idle_in(); soft_rst = 1'b1; pc_valid = 1'b1; pc = 32'h3000_0100;
    tick("R11 soft reset");
    idle_in();
    for (int c = 0; c < NCH; c++) rd("R11 cleared", c, 3);
    rd("R11 addr cleared", 2, 0);

    // random phase: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int n = 0; n < 4000; n++) begin
      int c;
      idle_in();
      dbg_mode = ($urandom_range(0, 9) != 0);
      soft_rst = ($urandom_range(0, 199) == 0);
      if ($urandom_range(0, 2) == 0) begin
        reg_wr = 1'b1;
        reg_addr = {4'($urandom_range(0, 5)), 2'($urandom_range(0, 3))};
        case (reg_addr[1:0])
          2'd1: reg_wdata = $urandom & 32'h0000_00FF;
          2'd2: reg_wdata = $urandom_range(0, 3);
          2'd3: reg_wdata = $urandom & 32'hF;
          default: reg_wdata = $urandom & 32'hF000_0F00;
        endcase
      end
      pc_valid = ($urandom_range(0, 3) != 0);
      c = $urandom_range(0, NCH - 1);
      pc = m_addr[c] ^ (($urandom_range(0, 3) == 0) ? (32'h1 << $urandom_range(0, 31))
                                                   : ($urandom & 32'h0000_00FF));
      asid = 8'($urandom_range(0, 3));
      tick("R4 R5 random");
      reg_wr = 1'b0;
      rd("R6 R10 random read", $urandom_range(0, 5), $urandom_range(0, 3));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule